// File: doc/BRIEF.md
# Configuration Sequencing Controller

This block steps a programmable device through its configuration life cycle after power is applied or a reprogram is requested. It advances on a slow one-cycle timer strobe (`tick`). The states are, in order: power-on hold-off, configuration-memory wipe, waiting for the external reset to clear, configuration load, start-up and user operation. A power-down state is reachable only from user operation. An error state holds the device after a framing fault reported by the loader.

The block does not shift the bitstream. An external loader reports completion (`load_done`) or a stop-bit framing fault (`stop_err`) as one-cycle strobes. The controller tells that loader which load mode the mode pins selected, and whether the configuration clock is driven out. It also drives the open-drain active-low init line as a pull-low enable, and controls tristating and pull-ups of the user pins. Every interface is a plain level or a strobe. No data flows through the block, so no valid/ready handshake is used and there is no back-pressure.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: After `por_n` rises, the hold-off lasts exactly 2^MASTER_EXP ticks when the mode pins select a master mode (pins 000, 001 or 011) and 2^SLAVE_EXP ticks otherwise. Throughout the hold-off, `init_drive_low`, `io_tristate` and `io_pullup` are 1 and `clr_en` is 0.
- R2: The wipe state lasts exactly CLEAR_TICKS ticks. While it lasts, `clr_en` and `init_drive_low` are 1.
- R3: `init_drive_low` is released only in the cycle where the wipe ends. It never falls while hold-off is running or when no wipe has just completed.
- R4: After the wipe, loading begins only when `ext_rst_n` is high and the mode pins hold a non-reserved code. The reserved codes 010, 100 and 110 keep the block waiting. The move to loading occurs one clock after both conditions hold.
- R5: `mode_pins` is {M0,M1,M2}, with bit 2 = M0. On entry to loading, the mode is sampled into `cfg_mode` and then held constant until the next entry. The mapping is: 000 → 0 (master serial); 001 → 1 (master byte, address up); 011 → 2 (master byte, address down); 101 → 3 (peripheral byte); 111 → 4 (slave serial). `cclk_out` is 1 for codes 0 to 3 and 0 for code 4.
- R6: During loading, `ext_rst_n` held low for ABORT_TICKS consecutive ticks returns the block to the wipe. A shorter low pulse has no effect, and the tick count restarts whenever `ext_rst_n` goes high. The next load re-samples the mode pins.
- R7: A `stop_err` strobe during loading enters the error state, where `init_drive_low` is 1 and `clr_en` is 0. The block stays there until `ext_rst_n` and `done_prog_n` are both low, which starts a wipe.
- R8: `pwrdn_req` is ignored during hold-off. In user operation it raises `pdown_active`, with `io_pullup` 0 and `io_tristate` 1. When `pwrdn_req` drops, the block returns to user operation.
- R9: A `load_done` strobe during loading enters start-up for exactly STARTUP_TICKS ticks, with `io_tristate` still 1. After that, `user_active` is 1 and `io_tristate` and `io_pullup` are 0.
- R10: In user operation, `ext_rst_n` and `done_prog_n` both low starts a wipe in the next cycle.
- R11: If strobes coincide during loading, `stop_err` wins over the abort tick, and the abort tick wins over `load_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tick | input | 1 | One-cycle strobe from the slow internal timer |
| ext_rst_n | input | 1 | External reset pin, active low |
| done_prog_n | input | 1 | Done/program pin level, active low |
| mode_pins | input | 3 | {M0,M1,M2} mode selection |
| pwrdn_req | input | 1 | Power-down request |
| stop_err | input | 1 | Stop-bit framing error strobe from the loader |
| load_done | input | 1 | Load-complete strobe from the loader |
| init_drive_low | output | 1 | 1 pulls the open-drain init line low |
| clr_en | output | 1 | Configuration-memory wipe enable |
| cfg_mode | output | 3 | Sampled load mode code |
| cclk_out | output | 1 | 1 when the configuration clock is driven out |
| io_tristate | output | 1 | 1 tristates the user pins |
| io_pullup | output | 1 | 1 enables the weak pull-ups on the user pins |
| cfg_active | output | 1 | Configuration load in progress |
| user_active | output | 1 | User operation |
| pdown_active | output | 1 | Power-down state |

## Verification
During loading, the third consecutive low tick on `ext_rst_n` (the abort) can land in the same cycle as a `stop_err` strobe or a `load_done` strobe. The bench sets up two low ticks and then raises the third tick together with the competing strobe on one clock edge. It then judges the outcome at the ports. After the collision with `stop_err`, `init_drive_low` must be high with `clr_en` low. After the collision with `load_done`, `clr_en` must be high with `cfg_active` low. Randomly chosen modes and short reset pulses surround these directed cases.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    ST_POR   = 3'd0,
    ST_CLEAR = 3'd1,
    ST_WAIT  = 3'd2,
    ST_LOAD  = 3'd3,
    ST_START = 3'd4,
    ST_OPER  = 3'd5,
    ST_ERR   = 3'd6,
    ST_PDOWN = 3'd7
  } seq_state_t;

  typedef enum logic [2:0] {
    CM_MSER  = 3'd0,
    CM_MUP   = 3'd1,
    CM_MDN   = 3'd2,
    CM_PBYTE = 3'd3,
    CM_SSER  = 3'd4,
    CM_RSVD  = 3'd7
  } cfg_mode_t;

endpackage

// File: rtl/cfg_mode_decode.sv
module cfg_mode_decode
  import cfg_seq_pkg::*;
(
  input  logic [2:0] pins,
  output cfg_mode_t  code,
  output logic       valid,
  output logic       is_master,
  output logic       cclk_drive
);
  always_comb begin
    unique case (pins)
      3'b000:  code = CM_MSER;
      3'b001:  code = CM_MUP;
      3'b011:  code = CM_MDN;
      3'b101:  code = CM_PBYTE;
      3'b111:  code = CM_SSER;
      default: code = CM_RSVD;
    endcase
    valid      = (code != CM_RSVD);
    is_master  = (code == CM_MSER) || (code == CM_MUP) || (code == CM_MDN);
    cclk_drive = valid && (code != CM_SSER);
  end
endmodule

// File: rtl/cfg_tick_timer.sv
module cfg_tick_timer #(
  parameter int TW = 17
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          restart,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt;

  assign expire = tick && (cnt >= limit - TW'(1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      cnt <= '0;
    else if (restart)
      cnt <= '0;
    else if (tick && !expire)
      cnt <= cnt + TW'(1);
  end
endmodule

// File: rtl/cfg_reset_filter.sv
module cfg_reset_filter #(
  parameter int N = 3
) (
  input  logic clk,
  input  logic por_n,
  input  logic enable,
  input  logic rst_in_n,
  input  logic tick,
  output logic fire
);
  localparam int FW = (N < 2) ? 1 : $clog2(N + 1);

  logic [FW-1:0] run;

  assign fire = enable && !rst_in_n && tick && (run == FW'(N - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      run <= '0;
    else if (!enable || rst_in_n)
      run <= '0;
    else if (tick && run != FW'(N - 1))
      run <= run + FW'(1);
  end

  generate
    if (N > 1) begin : g_hist
      // R6: a high reset level in one cycle forbids an abort in the next
      p_pulse_restart_r6: assert property (@(posedge clk) disable iff (!por_n)
        rst_in_n |=> !fire);
    end
  endgenerate
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int SLAVE_EXP     = 14,
  parameter int MASTER_EXP    = 16,
  parameter int CLEAR_TICKS   = 200,
  parameter int STARTUP_TICKS = 4,
  parameter int ABORT_TICKS   = 3
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       tick,
  input  logic       ext_rst_n,
  input  logic       done_prog_n,
  input  logic [2:0] mode_pins,
  input  logic       pwrdn_req,
  input  logic       stop_err,
  input  logic       load_done,
  output logic       init_drive_low,
  output logic       clr_en,
  output logic [2:0] cfg_mode,
  output logic       cclk_out,
  output logic       io_tristate,
  output logic       io_pullup,
  output logic       cfg_active,
  output logic       user_active,
  output logic       pdown_active
);
  localparam int PW  = MASTER_EXP + 1;
  localparam int CW  = $clog2(CLEAR_TICKS + 1);
  localparam int SW  = $clog2(STARTUP_TICKS + 1);
  localparam int TW0 = (PW > CW) ? PW : CW;
  localparam int TW  = (TW0 > SW) ? TW0 : SW;

  seq_state_t st, nxt;
  cfg_mode_t  dec_code, mode_q;
  logic       dec_valid, dec_master, dec_cclk, cclk_q;
  logic       tmr_restart, tmr_expire, abort_fire, reprog;
  logic [TW-1:0] tmr_limit;

  cfg_mode_decode u_dec (
    .pins       (mode_pins),
    .code       (dec_code),
    .valid      (dec_valid),
    .is_master  (dec_master),
    .cclk_drive (dec_cclk)
  );

  always_comb begin
    unique case (st)
      ST_POR:   tmr_limit = dec_master ? (TW'(1) << MASTER_EXP) : (TW'(1) << SLAVE_EXP);
      ST_CLEAR: tmr_limit = TW'(CLEAR_TICKS);
      default:  tmr_limit = TW'(STARTUP_TICKS);
    endcase
  end

  assign tmr_restart = (st != nxt);

  cfg_tick_timer #(.TW(TW)) u_tmr (
    .clk     (clk),
    .por_n   (por_n),
    .restart (tmr_restart),
    .tick    (tick),
    .limit   (tmr_limit),
    .expire  (tmr_expire)
  );

  cfg_reset_filter #(.N(ABORT_TICKS)) u_abort (
    .clk      (clk),
    .por_n    (por_n),
    .enable   (st == ST_LOAD),
    .rst_in_n (ext_rst_n),
    .tick     (tick),
    .fire     (abort_fire)
  );

  assign reprog = !ext_rst_n && !done_prog_n;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_POR:   if (tmr_expire) nxt = ST_CLEAR;
      ST_CLEAR: if (tmr_expire) nxt = ST_WAIT;
      ST_WAIT:  if (ext_rst_n && dec_valid) nxt = ST_LOAD;
      ST_LOAD: begin
        if (stop_err)        nxt = ST_ERR;
        else if (abort_fire) nxt = ST_CLEAR;
        else if (load_done)  nxt = ST_START;
      end
      ST_START: if (tmr_expire) nxt = ST_OPER;
      ST_OPER: begin
        if (reprog)         nxt = ST_CLEAR;
        else if (pwrdn_req) nxt = ST_PDOWN;
      end
      ST_PDOWN: if (!pwrdn_req) nxt = ST_OPER;
      ST_ERR:   if (reprog) nxt = ST_CLEAR;
      default:  nxt = ST_POR;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st     <= ST_POR;
      mode_q <= CM_RSVD;
      cclk_q <= 1'b0;
    end else begin
      st <= nxt;
      if (st == ST_WAIT && nxt == ST_LOAD) begin
        mode_q <= dec_code;
        cclk_q <= dec_cclk;
      end
    end
  end

  assign init_drive_low = (st == ST_POR) || (st == ST_CLEAR) || (st == ST_ERR);
  assign clr_en         = (st == ST_CLEAR);
  assign cfg_mode       = mode_q;
  assign cclk_out       = cclk_q;
  assign io_tristate    = (st != ST_OPER);
  assign io_pullup      = (st != ST_OPER) && (st != ST_PDOWN);
  assign cfg_active     = (st == ST_LOAD);
  assign user_active    = (st == ST_OPER);
  assign pdown_active   = (st == ST_PDOWN);

  // R3: init line released only as the wipe finishes
  p_init_release_r3: assert property (@(posedge clk) disable iff (!por_n)
    $fell(init_drive_low) |-> $past(clr_en));

  // R5: sampled mode held for the whole load
  p_mode_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_active && $past(cfg_active)) |-> $stable(cfg_mode));

  // R6: no abort while the reset pin is high
  p_no_early_abort_r6: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_LOAD && ext_rst_n) |=> (st != ST_CLEAR));

  // R7: error state held until a reprogram request
  p_err_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_ERR && (ext_rst_n || done_prog_n)) |=> (st == ST_ERR));

  // R8: power-down cannot interrupt the hold-off
  p_pdown_ignored_r8: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_POR) |=> (st == ST_POR || st == ST_CLEAR));

  // R11: framing error wins over every other load exit
  p_err_wins_r11: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_LOAD && stop_err) |=> (st == ST_ERR));
endmodule

// File: tb/cfg_seq_ctrl_test.sv
`timescale 1ns/1ps
module cfg_seq_ctrl_test;
  localparam int SEXP = 4;
  localparam int MEXP = 6;
  localparam int CLR  = 5;
  localparam int STU  = 3;
  localparam int ABT  = 3;

  logic clk = 1'b0;
  logic por_n = 1'b0, tick = 1'b0, ext_rst_n = 1'b0, done_prog_n = 1'b1;
  logic [2:0] mode_pins = 3'b111;
  logic pwrdn_req = 1'b0, stop_err = 1'b0, load_done = 1'b0;
  logic init_drive_low, clr_en, cclk_out, io_tristate, io_pullup;
  logic cfg_active, user_active, pdown_active;
  logic [2:0] cfg_mode;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cfg_seq_ctrl #(.SLAVE_EXP(SEXP), .MASTER_EXP(MEXP), .CLEAR_TICKS(CLR),
                 .STARTUP_TICKS(STU), .ABORT_TICKS(ABT)) uut (
    .clk(clk), .por_n(por_n), .tick(tick), .ext_rst_n(ext_rst_n),
    .done_prog_n(done_prog_n), .mode_pins(mode_pins), .pwrdn_req(pwrdn_req),
    .stop_err(stop_err), .load_done(load_done), .init_drive_low(init_drive_low),
    .clr_en(clr_en), .cfg_mode(cfg_mode), .cclk_out(cclk_out),
    .io_tristate(io_tristate), .io_pullup(io_pullup), .cfg_active(cfg_active),
    .user_active(user_active), .pdown_active(pdown_active));

  function automatic int exp_code(logic [2:0] p);
    case (p)
      3'b000: return 0;
      3'b001: return 1;
      3'b011: return 2;
      3'b101: return 3;
      3'b111: return 4;
      default: return 7;
    endcase
  endfunction

  function automatic int exp_cclk(logic [2:0] p);
    return (exp_code(p) <= 3) ? 1 : 0;
  endfunction

  function automatic bit exp_master(logic [2:0] p);
    return exp_code(p) <= 2;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick1();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  // called right after the wipe has been entered
  task automatic clear_and_enter(logic [2:0] pins, bit try_rsvd);
    ticks(CLR - 1);
    chk("R2", "clr_en mid wipe", clr_en, 1);
    chk("R2", "init low mid wipe", init_drive_low, 1);
    tick1();
    chk("R2", "clr_en after wipe", clr_en, 0);
    chk("R3", "init released after wipe", init_drive_low, 0);
    chk("R4", "wait while reset low", cfg_active, 0);
    if (try_rsvd) begin
      @(negedge clk) begin ext_rst_n = 1'b1; mode_pins = 3'b010; end
      repeat (3) @(negedge clk);
      chk("R4", "reserved code keeps waiting", cfg_active, 0);
    end
    @(negedge clk) begin ext_rst_n = 1'b1; mode_pins = pins; end
    @(negedge clk);
    chk("R4", "load entered", cfg_active, 1);
    chk("R5", "sampled mode", cfg_mode, exp_code(pins));
    chk("R5", "cclk direction", cclk_out, exp_cclk(pins));
  endtask

  task automatic short_pulse(int k);
    @(negedge clk) ext_rst_n = 1'b0;
    ticks(k);
    @(negedge clk) ext_rst_n = 1'b1;
    @(negedge clk);
    chk("R6", "short reset pulse ignored", cfg_active, 1);
  endtask

  task automatic finish_load();
    @(negedge clk) load_done = 1'b1;
    @(negedge clk) load_done = 1'b0;
    chk("R9", "start-up left load", cfg_active, 0);
    chk("R9", "pins tristated in start-up", io_tristate, 1);
    ticks(STU - 1);
    chk("R9", "not yet operational", user_active, 0);
    tick1();
    chk("R9", "operational", user_active, 1);
    chk("R9", "pins released", io_tristate, 0);
    chk("R9", "pull-ups off", io_pullup, 0);
  endtask

  task automatic reprogram();
    @(negedge clk) begin ext_rst_n = 1'b0; done_prog_n = 1'b0; end
    @(negedge clk) done_prog_n = 1'b1;
    chk("R10", "reprogram starts wipe", clr_en, 1);
  endtask

  task automatic power_on(logic [2:0] pins);
    int len;
    len = exp_master(pins) ? (1 << MEXP) : (1 << SEXP);
    @(negedge clk) begin por_n = 1'b0; ext_rst_n = 1'b0; mode_pins = pins; end
    @(negedge clk);
    chk("R1", "reset init low", init_drive_low, 1);
    chk("R1", "reset tristate", io_tristate, 1);
    chk("R1", "reset pull-up", io_pullup, 1);
    @(negedge clk) begin por_n = 1'b1; pwrdn_req = 1'b1; end
    ticks(len - 1);
    chk("R1", "hold-off still running", clr_en, 0);
    chk("R1", "init low in hold-off", init_drive_low, 1);
    chk("R8", "power-down ignored in hold-off", pdown_active, 0);
    chk("R1", "pull-up in hold-off", io_pullup, 1);
    tick1();
    chk("R1", "hold-off length", clr_en, 1);
    pwrdn_req = 1'b0;
  endtask

  initial begin
    logic [2:0] valid_codes [5];
    logic [2:0] p;
    void'($urandom(32'd2024));
    valid_codes[0] = 3'b000; valid_codes[1] = 3'b001; valid_codes[2] = 3'b011;
    valid_codes[3] = 3'b101; valid_codes[4] = 3'b111;

    // slave-mode power-up
    power_on(3'b111);
    clear_and_enter(3'b111, 1'b1);
    @(negedge clk) mode_pins = 3'b000;
    @(negedge clk);
    chk("R5", "mode held when pins change", cfg_mode, 4);
    short_pulse(2);
    short_pulse(2);

    // abort then re-sample
    @(negedge clk) ext_rst_n = 1'b0;
    ticks(ABT - 1);
    chk("R6", "not aborted before limit", cfg_active, 1);
    tick1();
    chk("R6", "abort to wipe", clr_en, 1);
    clear_and_enter(3'b011, 1'b0);

    finish_load();
    @(negedge clk) pwrdn_req = 1'b1;
    @(negedge clk);
    chk("R8", "power-down entered", pdown_active, 1);
    chk("R8", "pull-ups off in power-down", io_pullup, 0);
    chk("R8", "pins tristated in power-down", io_tristate, 1);
    @(negedge clk) pwrdn_req = 1'b0;
    @(negedge clk);
    chk("R8", "back to operation", user_active, 1);

    // framing error and its hold
    reprogram();
    clear_and_enter(3'b101, 1'b0);
    @(negedge clk) stop_err = 1'b1;
    @(negedge clk) stop_err = 1'b0;
    chk("R7", "error drives init low", init_drive_low, 1);
    chk("R7", "error is not wipe", clr_en, 0);
    @(negedge clk) ext_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7", "error held on reset alone", clr_en, 0);
    @(negedge clk) done_prog_n = 1'b0;
    @(negedge clk) done_prog_n = 1'b1;
    chk("R7", "reprogram leaves error", clr_en, 1);

    // collision: error versus abort
    clear_and_enter(3'b001, 1'b0);
    @(negedge clk) ext_rst_n = 1'b0;
    ticks(ABT - 1);
    @(negedge clk) begin tick = 1'b1; stop_err = 1'b1; end
    @(negedge clk) begin tick = 1'b0; stop_err = 1'b0; end
    chk("R11", "error beats abort (init)", init_drive_low, 1);
    chk("R11", "error beats abort (clr)", clr_en, 0);
    @(negedge clk) done_prog_n = 1'b0;
    @(negedge clk) done_prog_n = 1'b1;

    // collision: abort versus done
    clear_and_enter(3'b000, 1'b0);
    @(negedge clk) ext_rst_n = 1'b0;
    ticks(ABT - 1);
    @(negedge clk) begin tick = 1'b1; load_done = 1'b1; end
    @(negedge clk) begin tick = 1'b0; load_done = 1'b0; end
    chk("R11", "abort beats done (clr)", clr_en, 1);
    chk("R11", "abort beats done (load)", cfg_active, 0);

    // random modes and pulses
    clear_and_enter(3'b111, 1'b0);
    finish_load();
    for (int it = 0; it < 8; it++) begin
      p = valid_codes[$urandom_range(0, 4)];
      reprogram();
      clear_and_enter(p, ($urandom_range(0, 1) == 1));
      short_pulse($urandom_range(1, ABT - 1));
      finish_load();
    end

    // master-mode power-up length
    power_on(valid_codes[$urandom_range(0, 2)]);
    power_on(3'b101);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule